// File: doc/BRIEF.md
# Dynamic Warp Regrouping Pool

After a divergent branch, the threads of one warp split into two groups: those that took the branch and those that fell through. This block gathers such groups from many warps and rebuilds fuller warps out of them. A new warp holds only threads that stand at the same program counter and sit in different lanes. Each thread keeps its home lane, which is fixed by the low bits of its thread ID. Lanes stay fixed because register-file banks are tied to lanes.

Each accepted branch result is split into two staged update groups: one for the taken path and one for the fall-through path. Each group is resolved against a small table indexed by PC. That table points at the pool entry currently being filled for that PC. If the lanes are free, the group merges into that entry. If the PC is unknown, or its entry already uses one of the lanes, a fresh entry is opened and the table is pointed at it. A consumer pulls one regrouped warp at a time through a valid/ready issue port. The issue port gives the warp's PC, occupancy mask and per-lane thread IDs. Pulling a warp frees its entry.

The register file, the execution lanes and any lane swizzling belong to neighbouring blocks.

Top module: `dwf_warp_former`

## Requirements
- R1: After reset, `issue_valid_o` is 0 and `br_ready_o` is 1.
- R2: An accepted branch forms a taken group and a fall-through group. The taken group uses lanes `br_taken_i & br_active_i` and PC `br_pc_taken_i`. The fall-through group uses lanes `~br_taken_i & br_active_i` and PC `br_pc_fall_i`. The taken group is resolved first.
- R3: A group whose PC has a table mapping, and whose lanes do not overlap the mapped entry's occupancy, merges into that entry. The entry's occupancy becomes the OR of both masks, and its thread IDs are written in the group's lanes.
- R4: A group whose PC is mapped but whose lanes overlap the mapped entry opens a new entry at the lowest free index. The mapping is moved to that new entry, so later groups for that PC merge there. The old entry stays in the pool.
- R5: A group whose PC has no mapping opens a new entry at the lowest free pool index.
- R6: The thread ID for lane i always appears in lane i of `issue_tid_o`, at bits [i*TID_W +: TID_W]. Lanes that are not occupied read as zero.
- R7: `issue_valid_o` is 1 exactly when the pool holds an entry. The issued entry is the one with the most occupied lanes; ties go to the lowest index.
- R8: An issue handshake (`issue_valid_o && issue_ready_i`) frees the issued entry and removes any table mapping to it. A later group for the same PC then opens a new entry.
- R9: A group with an all-zero lane mask is dropped and leaves the pool unchanged. An accepted branch with `br_active_i == 0` leaves `br_ready_o` high in the very next cycle.
- R10: When a group needs a new entry and the pool is full, the group waits and `br_ready_o` stays 0. Resolution resumes after an issue frees an entry.
- R11: `br_ready_o` drops while staged groups are pending. It returns at most two cycles after acceptance when no stall or conflict with an issue occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| br_valid_i | input | 1 | Branch result valid |
| br_ready_o | output | 1 | Branch result accepted when high with valid |
| br_active_i | input | LANES | Lanes active in the branching warp |
| br_taken_i | input | LANES | Lanes that took the branch |
| br_tid_i | input | LANES*TID_W | Per-lane thread IDs, lane i at [i*TID_W +: TID_W] |
| br_pc_taken_i | input | PC_W | Branch target PC |
| br_pc_fall_i | input | PC_W | Fall-through PC |
| issue_valid_o | output | 1 | A regrouped warp is available |
| issue_ready_i | input | 1 | Consumer takes the offered warp |
| issue_pc_o | output | PC_W | PC of the offered warp |
| issue_mask_o | output | LANES | Occupied lanes of the offered warp |
| issue_tid_o | output | LANES*TID_W | Per-lane thread IDs of the offered warp |

## Verification
Two cases are the hardest to reach from the ports. One is a lane conflict that moves a PC mapping while the older entry for that PC is still pooled. The other is a full pool holding back a branch until an issue frees a slot. Random stimulus draws PCs from only four values and uses random active and taken masks, so overlapping and complementary lane sets occur often. Issues are interleaved randomly, so both mappings and entries are reused. A directed sequence fills every entry with distinct PCs, then sends one more full warp. The bench checks that the input stays blocked until one issue is taken.

// File: rtl/dwf_pkg.sv
package dwf_pkg;
  localparam int unsigned DEF_LANES = 4;
  localparam int unsigned DEF_TID_W = 8;
  localparam int unsigned DEF_PC_W  = 16;
  localparam int unsigned DEF_DEPTH = 4;

  typedef enum logic [1:0] {
    LUT_NOP,
    LUT_MERGE,
    LUT_REPOINT,
    LUT_NEW
  } lut_op_e;
endpackage

// File: rtl/dwf_update_regs.sv
module dwf_update_regs #(
  parameter int unsigned LANES = 4,
  parameter int unsigned TID_W = 8,
  parameter int unsigned PC_W  = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   br_valid_i,
  output logic                   br_ready_o,
  input  logic [LANES-1:0]       br_active_i,
  input  logic [LANES-1:0]       br_taken_i,
  input  logic [LANES*TID_W-1:0] br_tid_i,
  input  logic [PC_W-1:0]        br_pc_taken_i,
  input  logic [PC_W-1:0]        br_pc_fall_i,
  output logic                   cur_valid_o,
  output logic [PC_W-1:0]        cur_pc_o,
  output logic [LANES-1:0]       cur_mask_o,
  output logic [LANES*TID_W-1:0] cur_tid_o,
  input  logic                   cur_done_i
);
  logic                   tk_v_q, ft_v_q;
  logic [PC_W-1:0]        tk_pc_q, ft_pc_q;
  logic [LANES-1:0]       tk_mask_q, ft_mask_q;
  logic [LANES*TID_W-1:0] tid_q;
  logic [LANES-1:0]       tk_mask_d, ft_mask_d;
  logic                   accept;

  assign br_ready_o = !tk_v_q && !ft_v_q;
  assign accept     = br_valid_i && br_ready_o;
  assign tk_mask_d  = br_taken_i & br_active_i;
  assign ft_mask_d  = ~br_taken_i & br_active_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tk_v_q    <= 1'b0;
      ft_v_q    <= 1'b0;
      tk_pc_q   <= '0;
      ft_pc_q   <= '0;
      tk_mask_q <= '0;
      ft_mask_q <= '0;
      tid_q     <= '0;
    end else if (accept) begin
      // all-zero groups are never staged
      tk_v_q    <= |tk_mask_d;
      ft_v_q    <= |ft_mask_d;
      tk_pc_q   <= br_pc_taken_i;
      ft_pc_q   <= br_pc_fall_i;
      tk_mask_q <= tk_mask_d;
      ft_mask_q <= ft_mask_d;
      tid_q     <= br_tid_i;
    end else if (cur_done_i) begin
      if (tk_v_q) tk_v_q <= 1'b0;
      else        ft_v_q <= 1'b0;
    end
  end

  // taken group resolves first
  assign cur_valid_o = tk_v_q || ft_v_q;
  assign cur_pc_o    = tk_v_q ? tk_pc_q : ft_pc_q;
  assign cur_mask_o  = tk_v_q ? tk_mask_q : ft_mask_q;
  assign cur_tid_o   = tid_q;

  assert_done_needs_group_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_done_i |-> cur_valid_o);
  assert_zero_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && br_active_i == '0) |=> br_ready_o);
  assert_split_disjoint_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> ((tk_mask_q & ft_mask_q) == '0) && ((tk_mask_q | ft_mask_q) == $past(br_active_i)));
endmodule

// File: rtl/dwf_pc_lut.sv
module dwf_pc_lut
  import dwf_pkg::*;
#(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned LANES = 4,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PC_W-1:0]  look_pc_i,
  output logic             hit_o,
  output logic [LANES-1:0] hit_occ_o,
  output logic [IDX_W-1:0] hit_idx_o,
  input  lut_op_e          op_i,
  input  logic [LANES-1:0] op_mask_i,
  input  logic [IDX_W-1:0] op_idx_i,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] clr_idx_i
);
  localparam int unsigned SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] v_q;
  logic [PC_W-1:0]  pc_q  [DEPTH];
  logic [LANES-1:0] occ_q [DEPTH];
  logic [IDX_W-1:0] idx_q [DEPTH];
  logic [DEPTH-1:0] match;
  logic [SLOT_W-1:0] hit_slot, free_slot;
  logic              has_free;

  always_comb begin
    hit_slot  = '0;
    free_slot = '0;
    has_free  = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      match[i] = v_q[i] && (pc_q[i] == look_pc_i);
      if (match[i]) hit_slot = SLOT_W'(i);
      if (!v_q[i]) begin
        free_slot = SLOT_W'(i);
        has_free  = 1'b1;
      end
    end
  end

  assign hit_o     = |match;
  assign hit_occ_o = occ_q[hit_slot];
  assign hit_idx_o = idx_q[hit_slot];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= '0;
      for (int e = 0; e < DEPTH; e++) begin
        pc_q[e]  <= '0;
        occ_q[e] <= '0;
        idx_q[e] <= '0;
      end
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (op_i == LUT_MERGE && hit_o && hit_slot == SLOT_W'(e)) begin
          occ_q[e] <= occ_q[e] | op_mask_i;
        end else if (op_i == LUT_REPOINT && hit_o && hit_slot == SLOT_W'(e)) begin
          occ_q[e] <= op_mask_i;
          idx_q[e] <= op_idx_i;
        end else if (op_i == LUT_NEW && free_slot == SLOT_W'(e)) begin
          v_q[e]   <= 1'b1;
          pc_q[e]  <= look_pc_i;
          occ_q[e] <= op_mask_i;
          idx_q[e] <= op_idx_i;
        end else if (clr_i && v_q[e] && idx_q[e] == clr_idx_i) begin
          v_q[e] <= 1'b0;
        end
      end
    end
  end

  assert_one_map_per_pc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));
  assert_new_has_room_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == LUT_NEW) |-> (has_free && !hit_o));
  assert_repoint_moves_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == LUT_REPOINT) |=> (hit_o && hit_idx_o == $past(op_idx_i)) || !($stable(look_pc_i)));
endmodule

// File: rtl/dwf_warp_pool.sv
module dwf_warp_pool #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned TID_W  = 8,
  parameter int unsigned PC_W   = 16,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int unsigned PRIO_W = $clog2(LANES + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_merge_i,
  input  logic                    wr_alloc_i,
  input  logic [IDX_W-1:0]        wr_idx_i,
  input  logic [PC_W-1:0]         upd_pc_i,
  input  logic [LANES-1:0]        upd_mask_i,
  input  logic [LANES*TID_W-1:0]  upd_tid_i,
  input  logic                    free_i,
  input  logic [IDX_W-1:0]        free_idx_i,
  output logic                    has_free_o,
  output logic [IDX_W-1:0]        free_slot_o,
  output logic [DEPTH-1:0]        valid_o,
  output logic [DEPTH*PRIO_W-1:0] prio_o,
  input  logic [IDX_W-1:0]        rd_idx_i,
  output logic [PC_W-1:0]         rd_pc_o,
  output logic [LANES-1:0]        rd_occ_o,
  output logic [LANES*TID_W-1:0]  rd_tid_o
);
  logic [DEPTH-1:0]  v_q;
  logic [PC_W-1:0]   pc_q   [DEPTH];
  logic [LANES-1:0]  occ_q  [DEPTH];
  logic [PRIO_W-1:0] prio_q [DEPTH];
  logic [TID_W-1:0]  tid_q  [DEPTH][LANES];
  logic [LANES-1:0]  merged_occ;

  function automatic logic [PRIO_W-1:0] popcnt(input logic [LANES-1:0] m);
    logic [PRIO_W-1:0] c;
    c = '0;
    for (int i = 0; i < LANES; i++) c = c + PRIO_W'(m[i]);
    return c;
  endfunction

  always_comb begin
    has_free_o  = 1'b0;
    free_slot_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!v_q[i]) begin
        has_free_o  = 1'b1;
        free_slot_o = IDX_W'(i);
      end
    end
  end

  assign merged_occ = occ_q[wr_idx_i] | upd_mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= '0;
      for (int e = 0; e < DEPTH; e++) begin
        pc_q[e]   <= '0;
        occ_q[e]  <= '0;
        prio_q[e] <= '0;
        for (int l = 0; l < LANES; l++) tid_q[e][l] <= '0;
      end
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (wr_alloc_i && free_slot_o == IDX_W'(e)) begin
          v_q[e]    <= 1'b1;
          pc_q[e]   <= upd_pc_i;
          occ_q[e]  <= upd_mask_i;
          prio_q[e] <= popcnt(upd_mask_i);
          for (int l = 0; l < LANES; l++)
            tid_q[e][l] <= upd_mask_i[l] ? upd_tid_i[l*TID_W +: TID_W] : '0;
        end else if (wr_merge_i && wr_idx_i == IDX_W'(e)) begin
          occ_q[e]  <= merged_occ;
          prio_q[e] <= popcnt(merged_occ);
          for (int l = 0; l < LANES; l++)
            if (upd_mask_i[l]) tid_q[e][l] <= upd_tid_i[l*TID_W +: TID_W];
        end else if (free_i && free_idx_i == IDX_W'(e)) begin
          v_q[e]    <= 1'b0;
          occ_q[e]  <= '0;
          prio_q[e] <= '0;
          for (int l = 0; l < LANES; l++) tid_q[e][l] <= '0;
        end
      end
    end
  end

  assign valid_o  = v_q;
  assign rd_pc_o  = pc_q[rd_idx_i];
  assign rd_occ_o = occ_q[rd_idx_i];

  for (genvar e = 0; e < DEPTH; e++) begin : g_prio
    assign prio_o[e*PRIO_W +: PRIO_W] = prio_q[e];
  end
  for (genvar l = 0; l < LANES; l++) begin : g_rd
    assign rd_tid_o[l*TID_W +: TID_W] = tid_q[rd_idx_i][l];
  end

  assert_merge_target_free_lanes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_merge_i |-> (v_q[wr_idx_i] && ((occ_q[wr_idx_i] & upd_mask_i) == '0)));
  assert_merge_keeps_lanes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_merge_i && !wr_alloc_i) |=> ((occ_q[$past(wr_idx_i)] & $past(upd_mask_i)) == $past(upd_mask_i)));
  assert_alloc_needs_room_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_alloc_i |-> has_free_o);
  assert_issue_frees_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_i |=> !v_q[$past(free_idx_i)]);
endmodule

// File: rtl/dwf_issue_arb.sv
module dwf_issue_arb #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int unsigned PRIO_W = 3
) (
  input  logic [DEPTH-1:0]        valid_i,
  input  logic [DEPTH*PRIO_W-1:0] prio_i,
  output logic                    any_o,
  output logic [IDX_W-1:0]        sel_o
);
  logic [PRIO_W-1:0] best;

  always_comb begin
    any_o = 1'b0;
    sel_o = '0;
    best  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      // strict compare keeps the lowest index on a tie
      if (valid_i[i] && (!any_o || prio_i[i*PRIO_W +: PRIO_W] > best)) begin
        any_o = 1'b1;
        sel_o = IDX_W'(i);
        best  = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/dwf_warp_former.sv
module dwf_warp_former
  import dwf_pkg::*;
#(
  parameter int unsigned LANES = DEF_LANES,
  parameter int unsigned TID_W = DEF_TID_W,
  parameter int unsigned PC_W  = DEF_PC_W,
  parameter int unsigned DEPTH = DEF_DEPTH
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   br_valid_i,
  output logic                   br_ready_o,
  input  logic [LANES-1:0]       br_active_i,
  input  logic [LANES-1:0]       br_taken_i,
  input  logic [LANES*TID_W-1:0] br_tid_i,
  input  logic [PC_W-1:0]        br_pc_taken_i,
  input  logic [PC_W-1:0]        br_pc_fall_i,
  output logic                   issue_valid_o,
  input  logic                   issue_ready_i,
  output logic [PC_W-1:0]        issue_pc_o,
  output logic [LANES-1:0]       issue_mask_o,
  output logic [LANES*TID_W-1:0] issue_tid_o
);
  localparam int unsigned IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned PRIO_W = $clog2(LANES + 1);

  logic                    cur_valid, cur_done;
  logic [PC_W-1:0]         cur_pc;
  logic [LANES-1:0]        cur_mask;
  logic [LANES*TID_W-1:0]  cur_tid;
  logic                    lut_hit;
  logic [LANES-1:0]        lut_occ;
  logic [IDX_W-1:0]        lut_idx;
  lut_op_e                 lut_op;
  logic                    pool_has_free;
  logic [IDX_W-1:0]        pool_free_slot, sel_idx;
  logic [DEPTH-1:0]        pool_valid;
  logic [DEPTH*PRIO_W-1:0] pool_prio;
  logic                    fits, tgt_busy, do_merge, do_alloc, issue_fire;

  dwf_update_regs #(.LANES(LANES), .TID_W(TID_W), .PC_W(PC_W)) u_upd (
    .clk_i, .rst_ni, .br_valid_i, .br_ready_o, .br_active_i, .br_taken_i,
    .br_tid_i, .br_pc_taken_i, .br_pc_fall_i,
    .cur_valid_o(cur_valid), .cur_pc_o(cur_pc), .cur_mask_o(cur_mask),
    .cur_tid_o(cur_tid), .cur_done_i(cur_done)
  );

  dwf_pc_lut #(.PC_W(PC_W), .LANES(LANES), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_lut (
    .clk_i, .rst_ni, .look_pc_i(cur_pc),
    .hit_o(lut_hit), .hit_occ_o(lut_occ), .hit_idx_o(lut_idx),
    .op_i(lut_op), .op_mask_i(cur_mask), .op_idx_i(pool_free_slot),
    .clr_i(issue_fire), .clr_idx_i(sel_idx)
  );

  assign issue_fire = issue_valid_o && issue_ready_i;
  assign fits       = lut_hit && ((lut_occ & cur_mask) == '0);
  // hold a group whose mapped entry is leaving this cycle
  assign tgt_busy   = issue_fire && lut_hit && (lut_idx == sel_idx);
  assign do_merge   = cur_valid && fits && !tgt_busy;
  assign do_alloc   = cur_valid && !fits && pool_has_free && !tgt_busy;
  assign cur_done   = do_merge || do_alloc;

  always_comb begin
    if (do_merge)              lut_op = LUT_MERGE;
    else if (do_alloc && lut_hit) lut_op = LUT_REPOINT;
    else if (do_alloc)         lut_op = LUT_NEW;
    else                       lut_op = LUT_NOP;
  end

  dwf_warp_pool #(.LANES(LANES), .TID_W(TID_W), .PC_W(PC_W), .DEPTH(DEPTH),
                  .IDX_W(IDX_W), .PRIO_W(PRIO_W)) u_pool (
    .clk_i, .rst_ni,
    .wr_merge_i(do_merge), .wr_alloc_i(do_alloc), .wr_idx_i(lut_idx),
    .upd_pc_i(cur_pc), .upd_mask_i(cur_mask), .upd_tid_i(cur_tid),
    .free_i(issue_fire), .free_idx_i(sel_idx),
    .has_free_o(pool_has_free), .free_slot_o(pool_free_slot),
    .valid_o(pool_valid), .prio_o(pool_prio),
    .rd_idx_i(sel_idx), .rd_pc_o(issue_pc_o), .rd_occ_o(issue_mask_o), .rd_tid_o(issue_tid_o)
  );

  dwf_issue_arb #(.DEPTH(DEPTH), .IDX_W(IDX_W), .PRIO_W(PRIO_W)) u_arb (
    .valid_i(pool_valid), .prio_i(pool_prio), .any_o(issue_valid_o), .sel_o(sel_idx)
  );

  assert_issue_nonempty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> (issue_mask_o != '0));
  assert_issue_iff_pooled_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o == (pool_valid != '0));
  assert_full_stall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_valid && !fits && !pool_has_free) |=> !br_ready_o);
  for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
    assert_idle_lane_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (issue_valid_o && !issue_mask_o[l]) |-> (issue_tid_o[l*TID_W +: TID_W] == '0));
  end
endmodule

// File: tb/sim_dwf_warp_former.sv
module sim_dwf_warp_former;
  localparam int LANES = 4;
  localparam int TID_W = 8;
  localparam int PC_W  = 16;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic br_valid_i = 1'b0;
  logic br_ready_o;
  logic [LANES-1:0] br_active_i = '0, br_taken_i = '0;
  logic [LANES*TID_W-1:0] br_tid_i = '0;
  logic [PC_W-1:0] br_pc_taken_i = '0, br_pc_fall_i = '0;
  logic issue_valid_o;
  logic issue_ready_i = 1'b0;
  logic [PC_W-1:0] issue_pc_o;
  logic [LANES-1:0] issue_mask_o;
  logic [LANES*TID_W-1:0] issue_tid_o;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  dwf_warp_former #(.LANES(LANES), .TID_W(TID_W), .PC_W(PC_W), .DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni, .br_valid_i, .br_ready_o, .br_active_i, .br_taken_i,
    .br_tid_i, .br_pc_taken_i, .br_pc_fall_i, .issue_valid_o, .issue_ready_i,
    .issue_pc_o, .issue_mask_o, .issue_tid_o
  );

  // expected-state model
  bit        m_v   [DEPTH];
  bit [15:0] m_pc  [DEPTH];
  bit [3:0]  m_occ [DEPTH];
  bit [31:0] m_tid [DEPTH];
  bit        l_v   [DEPTH];
  bit [15:0] l_pc  [DEPTH];
  bit [3:0]  l_occ [DEPTH];
  int        l_idx [DEPTH];

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  function automatic int m_free();
    int n = 0;
    for (int i = 0; i < DEPTH; i++) if (!m_v[i]) n++;
    return n;
  endfunction

  function automatic int m_sel();
    int s = -1;
    for (int i = 0; i < DEPTH; i++)
      if (m_v[i] && (s < 0 || $countones(m_occ[i]) > $countones(m_occ[s]))) s = i;
    return s;
  endfunction

  task automatic m_apply(input bit [15:0] pc, input bit [3:0] mask, input bit [31:0] tids);
    int h = -1;
    int f = -1;
    if (mask == 0) return;
    for (int i = 0; i < DEPTH; i++) if (l_v[i] && l_pc[i] == pc) h = i;
    if (h >= 0 && (l_occ[h] & mask) == 0) begin
      int e = l_idx[h];
      m_occ[e] |= mask;
      for (int l = 0; l < LANES; l++) if (mask[l]) m_tid[e][l*8 +: 8] = tids[l*8 +: 8];
      l_occ[h] |= mask;
    end else begin
      for (int i = DEPTH - 1; i >= 0; i--) if (!m_v[i]) f = i;
      m_v[f] = 1; m_pc[f] = pc; m_occ[f] = mask; m_tid[f] = '0;
      for (int l = 0; l < LANES; l++) if (mask[l]) m_tid[f][l*8 +: 8] = tids[l*8 +: 8];
      if (h >= 0) begin
        l_idx[h] = f; l_occ[h] = mask;
      end else begin
        int k = -1;
        for (int i = DEPTH - 1; i >= 0; i--) if (!l_v[i]) k = i;
        l_v[k] = 1; l_pc[k] = pc; l_occ[k] = mask; l_idx[k] = f;
      end
    end
  endtask

  task automatic pop();
    int s;
    @(negedge clk);
    s = m_sel();
    chk(issue_valid_o == (s >= 0), "R7 issue_valid", issue_valid_o, s >= 0);
    if (s < 0) return;
    chk(issue_pc_o == m_pc[s], "R7 issue pc (priority/tie order)", issue_pc_o, m_pc[s]);
    chk(issue_mask_o == m_occ[s], "R3 issue mask", issue_mask_o, m_occ[s]);
    chk(issue_tid_o == m_tid[s], "R6 issue tids by home lane", issue_tid_o, m_tid[s]);
    issue_ready_i = 1'b1;
    @(posedge clk); #1;
    issue_ready_i = 1'b0;
    m_v[s] = 0;
    for (int i = 0; i < DEPTH; i++) if (l_v[i] && l_idx[i] == s) l_v[i] = 0; // R8 model
  endtask

  task automatic drive(input bit [3:0] act, input bit [3:0] tk, input bit [31:0] tids,
                       input bit [15:0] pt, input bit [15:0] pf);
    @(negedge clk);
    br_valid_i = 1'b1; br_active_i = act; br_taken_i = tk; br_tid_i = tids;
    br_pc_taken_i = pt; br_pc_fall_i = pf;
    @(posedge clk); #1;
    br_valid_i = 1'b0;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    @(negedge clk);
    while (!br_ready_o && n < 40) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic send(input bit [3:0] act, input bit [3:0] tk, input bit [31:0] tids,
                      input bit [15:0] pt, input bit [15:0] pf);
    int n;
    drive(act, tk, tids, pt, pf);
    wait_ready(n);
    chk(n <= 2, "R11 ready latency", n, 2);
    m_apply(pt, tk & act, tids);   // R2 taken first
    m_apply(pf, ~tk & act, tids);
  endtask

  function automatic bit [31:0] gen_tids();
    bit [31:0] t;
    for (int l = 0; l < LANES; l++) t[l*8 +: 8] = 8'(($urandom & 32'hFC) | l);
    return t;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit [15:0] pcs [4];
    int n;
    int seed;
    seed = $urandom(32'h1d5);
    pcs[0] = 16'h0100; pcs[1] = 16'h0140; pcs[2] = 16'h0180; pcs[3] = 16'h01C0;
    for (int i = 0; i < DEPTH; i++) begin m_v[i] = 0; l_v[i] = 0; end

    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    chk(issue_valid_o == 0, "R1 reset issue_valid", issue_valid_o, 0);
    chk(br_ready_o == 1, "R1 reset br_ready", br_ready_o, 1);

    // R9: empty active mask drops both groups
    drive(4'b0000, 4'b0101, 32'h03020100, pcs[0], pcs[1]);
    wait_ready(n);
    chk(n == 0, "R9 zero-mask ready next cycle", n, 0);
    chk(issue_valid_o == 0, "R9 zero-mask leaves pool empty", issue_valid_o, 0);

    // R2/R5/R3: split, allocate, then complementary merge
    send(4'b1111, 4'b0110, 32'h13121110, pcs[0], pcs[1]);
    send(4'b1111, 4'b1001, 32'h27262524, pcs[0], pcs[1]);
    pop(); // both full, tie -> index 0 holding the taken PC (R2, R7)
    pop();

    // R4: overlap forces a second entry, later group merges into the new one
    send(4'b0011, 4'b0011, 32'h33323130, pcs[2], pcs[3]);
    send(4'b0001, 4'b0001, 32'h47464544, pcs[2], pcs[3]);
    send(4'b0100, 4'b0100, 32'h5b5a5958, pcs[2], pcs[3]);
    pop(); pop();
    // R8: issued PC reopens a fresh entry
    send(4'b1000, 4'b1000, 32'h6f6e6d6c, pcs[2], pcs[3]);
    pop();
    chk(issue_valid_o == 0, "R8 pool empty after drain", issue_valid_o, 0);

    // R10: full pool holds the input until an issue
    for (int i = 0; i < DEPTH; i++) send(4'b1111, 4'b1111, gen_tids(), 16'h0200 + 16'(i * 4), pcs[0]);
    drive(4'b1111, 4'b1111, 32'h77767574, 16'h0300, pcs[0]);
    repeat (6) @(negedge clk);
    chk(br_ready_o == 0, "R10 stalled while pool full", br_ready_o, 0);
    pop();
    wait_ready(n);
    chk(n <= 2, "R10 resumes after issue", n, 2);
    m_apply(16'h0300, 4'b1111, 32'h77767574);
    while (m_sel() >= 0) pop();

    // random mix
    for (int it = 0; it < 400; it++) begin
      while (m_free() < 2) pop();
      if ($urandom % 3 == 0 && m_sel() >= 0) pop();
      send(4'($urandom), 4'($urandom), gen_tids(), pcs[$urandom % 4], pcs[$urandom % 4]);
    end
    while (m_sel() >= 0) pop();
    @(negedge clk);
    chk(issue_valid_o == 0, "R7 no issue once drained", issue_valid_o, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule